// File: doc/BRIEF.md
# Byte-Lane Carry-less 64x64 Multiplier

This block forms the 128-bit carry-less product of two 64-bit operands, where each operand is read as a polynomial over GF(2). No wide multiplier is used. A row of eight independent 8x8 carry-less lane multipliers does all the arithmetic. Each lane produces a 16-bit partial product. On each clock cycle the row receives one byte-rotated pair of the operands. Over eight cycles every byte of one operand meets every byte of the other. Between passes, the lane vectors are combined by pairwise XOR, a fold of the upper half into the lower half under a lane mask, and a left shift by a whole number of bytes.

The host asserts `start_i` with both operands while the block is idle. The operands are captured on that edge and `busy_o` rises. Eight passes follow, one per cycle. The block then raises `done_o` for a single cycle, and `product_o` holds the final product. Passing the same value on both operands gives its polynomial square. The block does not reduce the product modulo any field polynomial.

Top module: `clmul64_lanes`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `product_o` is all zeros.
- R2: A `start_i` seen high on a rising edge while `busy_o` is low captures `a_i` and `b_i`, and `busy_o` is high from the following cycle onward.
- R3: `done_o` is high for exactly one cycle. That cycle begins on the 8th rising edge after the accepting edge. `busy_o` falls on the same edge that raises `done_o`.
- R4: When `done_o` is high, bit k of `product_o` equals the XOR over all index pairs i+j=k of a[i]&b[j]. This holds for zero operands, all-ones operands and arbitrary operands, and bit 127 is always 0.
- R5: A `start_i` raised while `busy_o` is high has no effect. The running operation keeps its operands and its timing, and it returns the product of the operands that were accepted.
- R6: While `busy_o` is low, `product_o` stays constant, whatever `a_i`, `b_i` and `start_i` do.
- R7: With equal operands, `product_o` is the square: bit 2i equals a[i], and every odd bit is 0.
- R8: For single-bit operands with bit i and bit j set (0 <= i, j < 64), `product_o` has exactly bit i+j set. This covers every lane position, every rotation and every fold path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication; acted on only when idle |
| a_i | input | 64 | First operand polynomial, bit i = coefficient of z^i |
| b_i | input | 64 | Second operand polynomial |
| busy_o | output | 1 | High while the eight passes are in progress |
| done_o | output | 1 | One-cycle pulse marking a valid product |
| product_o | output | 128 | Carry-less product, valid from `done_o` until the next operation's first pass |

## Verification
The assertions check the control behaviour on every cycle:
- the pass counter advances without a gap;
- the captured operands stay fixed while the block is busy;
- `done_o` is a one-cycle pulse that follows a busy cycle;
- the product stays still while idle;
- the top product bit stays clear;
- odd bits are clear whenever the operands are equal.

The arithmetic can only be shown by the bench's scenarios. These include the full sweep of single-bit operand pairs, which reaches every lane, rotation and fold mask. They also include zero, all-ones, random and squared operands compared against a bit-serial reference, a start request injected mid-operation, and an idle hold with toggling inputs.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

    localparam int LANE_W  = 8;
    localparam int LANES   = 8;
    localparam int OP_W    = LANE_W * LANES;
    localparam int PROD_W  = 2 * OP_W;
    localparam int LPROD_W = 2 * LANE_W;
    localparam int PASSES  = 8;

    typedef enum logic [2:0] {
        PS_DIAG  = 3'd0,
        PS_BR1   = 3'd1,
        PS_AR1   = 3'd2,
        PS_BR2   = 3'd3,
        PS_AR2   = 3'd4,
        PS_BR3   = 3'd5,
        PS_AR3   = 3'd6,
        PS_BR4   = 3'd7
    } pass_e;

    typedef struct packed {
        logic               busy;
        logic               done;
        pass_e              pass;
        logic [OP_W-1:0]    opa;
        logic [OP_W-1:0]    opb;
        logic [PROD_W-1:0]  acc;
        logic [PROD_W-1:0]  pair;
    } mul_state_t;

    function automatic logic [OP_W-1:0] rot_bytes(input logic [OP_W-1:0] x,
                                                  input int unsigned nbytes);
        logic [2*OP_W-1:0] wide;
        wide = {x, x} >> (nbytes * LANE_W);
        return wide[OP_W-1:0];
    endfunction

endpackage

// File: rtl/clmul_lane.sv
module clmul_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0]   x_i,
    input  logic [W-1:0]   y_i,
    output logic [2*W-1:0] p_o
);
    always_comb begin
        p_o = '0;
        for (int i = 0; i < W; i++) begin
            if (y_i[i]) begin
                p_o = p_o ^ ({{W{1'b0}}, x_i} << i);
            end
        end
    end
endmodule

// File: rtl/clmul_lane_array.sv
module clmul_lane_array
    import clmul_pkg::*;
(
    input  logic [OP_W-1:0]   x_i,
    input  logic [OP_W-1:0]   y_i,
    output logic [PROD_W-1:0] v_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        clmul_lane #(.W(LANE_W)) i_lane (
            .x_i (x_i[g*LANE_W +: LANE_W]),
            .y_i (y_i[g*LANE_W +: LANE_W]),
            .p_o (v_o[g*LPROD_W +: LPROD_W])
        );
    end
endmodule

// File: rtl/clmul_operand_sel.sv
module clmul_operand_sel
    import clmul_pkg::*;
(
    input  pass_e           pass_i,
    input  logic [OP_W-1:0] a_i,
    input  logic [OP_W-1:0] b_i,
    output logic [OP_W-1:0] x_o,
    output logic [OP_W-1:0] y_o
);
    always_comb begin
        x_o = a_i;
        y_o = b_i;
        unique case (pass_i)
            PS_DIAG: ;
            PS_BR1:  y_o = rot_bytes(b_i, 1);
            PS_AR1:  x_o = rot_bytes(a_i, 1);
            PS_BR2:  y_o = rot_bytes(b_i, 2);
            PS_AR2:  x_o = rot_bytes(a_i, 2);
            PS_BR3:  y_o = rot_bytes(b_i, 3);
            PS_AR3:  x_o = rot_bytes(a_i, 3);
            PS_BR4:  y_o = rot_bytes(b_i, 4);
            default: ;
        endcase
    end
endmodule

// File: rtl/clmul_fold.sv
module clmul_fold
    import clmul_pkg::*;
(
    input  logic [PROD_W-1:0] v_i,
    input  logic [2:0]        keep_hi_i,
    input  logic [2:0]        shift_i,
    output logic [PROD_W-1:0] f_o
);
    logic [OP_W-1:0]   lo_q1;
    logic [OP_W-1:0]   hi_m;
    logic [OP_W-1:0]   mask;
    logic [PROD_W-1:0] joined;

    always_comb begin
        for (int l = 0; l < LANES / 2; l++) begin
            mask[l*LPROD_W +: LPROD_W] = (l < int'(keep_hi_i)) ? '1 : '0;
        end
        lo_q1  = v_i[OP_W-1:0] ^ v_i[PROD_W-1:OP_W];
        hi_m   = v_i[PROD_W-1:OP_W] & mask;
        joined = {hi_m, lo_q1 ^ hi_m};
        f_o    = joined << (int'(shift_i) * LANE_W);
    end
endmodule

// File: rtl/clmul64_lanes.sv
module clmul64_lanes
    import clmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [PROD_W-1:0] product_o
);
    mul_state_t st_d, st_q;

    logic [OP_W-1:0]   sel_x, sel_y;
    logic [PROD_W-1:0] lanes_v;
    logic [PROD_W-1:0] fold_in, fold_out;
    logic [2:0]        fold_keep, fold_shift;

    clmul_operand_sel i_sel (
        .pass_i (st_q.pass),
        .a_i    (st_q.opa),
        .b_i    (st_q.opb),
        .x_o    (sel_x),
        .y_o    (sel_y)
    );

    clmul_lane_array i_lanes (
        .x_i (sel_x),
        .y_i (sel_y),
        .v_o (lanes_v)
    );

    clmul_fold i_fold (
        .v_i       (fold_in),
        .keep_hi_i (fold_keep),
        .shift_i   (fold_shift),
        .f_o       (fold_out)
    );

    always_comb begin
        fold_in    = st_q.pair ^ lanes_v;
        fold_keep  = 3'd0;
        fold_shift = 3'd0;
        unique case (st_q.pass)
            PS_AR1: begin fold_keep = 3'd3; fold_shift = 3'd1; end
            PS_AR2: begin fold_keep = 3'd2; fold_shift = 3'd2; end
            PS_AR3: begin fold_keep = 3'd1; fold_shift = 3'd3; end
            PS_BR4: begin fold_keep = 3'd0; fold_shift = 3'd4; fold_in = lanes_v; end
            default: ;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.pass = PS_DIAG;
                st_d.opa  = a_i;
                st_d.opb  = b_i;
            end
        end else begin
            st_d.pass = pass_e'(st_q.pass + 3'd1);
            unique case (st_q.pass)
                PS_DIAG:                st_d.acc  = lanes_v;
                PS_BR1, PS_BR2, PS_BR3: st_d.pair = lanes_v;
                PS_AR1, PS_AR2, PS_AR3: st_d.acc  = st_q.acc ^ fold_out;
                PS_BR4: begin
                    st_d.acc  = st_q.acc ^ fold_out;
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.pass = PS_DIAG;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, done: 1'b0, pass: PS_DIAG,
                      opa: '0, opb: '0, acc: '0, pair: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign product_o = st_q.acc;

    AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.pass != PS_BR4) |=> (busy_o && st_q.pass == pass_e'($past(st_q.pass) + 3'd1))); // R2
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && $past(st_q.pass) == PS_BR4 && !busy_o)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
    AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(st_q.opa) && $stable(st_q.opb))); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(product_o)); // R6
    AST_TOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !product_o[PROD_W-1]); // R4
    AST_SQUARE_ODD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && st_q.opa == st_q.opb) |-> ((product_o & {OP_W{2'b10}}) == '0)); // R7

endmodule

// File: tb/test_clmul64_lanes.sv
`timescale 1ns/1ps
module test_clmul64_lanes;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [63:0]  a_i = '0;
    logic [63:0]  b_i = '0;
    logic         busy_o, done_o;
    logic [127:0] product_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    clmul64_lanes i_clmul64_lanes (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
    );

    function automatic logic [127:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] r = '0;
        for (int i = 0; i < 64; i++) if (b[i]) r = r ^ ({64'd0, a} << i);
        return r;
    endfunction

    function automatic logic [127:0] ref_square(input logic [63:0] a);
        logic [127:0] r = '0;
        for (int i = 0; i < 64; i++) r[2*i] = a[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive start at a negedge; accepting posedge follows. Done must be seen at the
    // 8th negedge after the one that clears start (R2, R3).
    task automatic run_op(input logic [63:0] a, input logic [63:0] b, output logic [127:0] p);
        int lat = 0;
        @(negedge clk);
        a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy after accept", {127'd0, busy_o}, 128'd1);
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R3 latency", lat, 8);
        check("R3 busy low at done", {127'd0, busy_o}, 128'd0);
        p = product_o;
    endtask

    logic [127:0] p;
    logic [63:0]  ra, rb;

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", {127'd0, busy_o}, 128'd0);
        check("R1 done", {127'd0, done_o}, 128'd0);
        check("R1 product", product_o, 128'd0);
        rst_n = 1'b1;

        run_op(64'd0, 64'hDEADBEEF_01234567, p);
        check("R4 zero a", p, 128'd0);
        run_op(64'hFEDCBA98_76543210, 64'd0, p);
        check("R4 zero b", p, 128'd0);
        run_op('1, '1, p);
        check("R4 all ones", p, ref_mul('1, '1));
        check("R7 all ones square", p, ref_square('1));

        // R3: pulse is a single cycle
        @(negedge clk);
        check("R3 done one cycle", {127'd0, done_o}, 128'd0);

        // R8: every single-bit pair
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                run_op(64'd1 << i, 64'd1 << j, p);
                check("R8 single bits", p, 128'd1 << (i + j));
            end
        end

        // R4: random operands
        for (int k = 0; k < 300; k++) begin
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            run_op(ra, rb, p);
            check("R4 random", p, ref_mul(ra, rb));
        end

        // R7: squaring
        for (int k = 0; k < 50; k++) begin
            ra = {$urandom(), $urandom()};
            run_op(ra, ra, p);
            check("R7 square", p, ref_square(ra));
        end

        // R5: start while busy is ignored
        begin
            int lat = 0;
            logic [63:0] a1 = 64'h0123456789ABCDEF, b1 = 64'hF0E1D2C3B4A59687;
            @(negedge clk);
            a_i = a1; b_i = b1; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            @(negedge clk); lat++;
            a_i = 64'hAAAA5555AAAA5555; b_i = 64'h1; start_i = 1'b1;
            @(negedge clk); lat++;
            start_i = 1'b0;
            check("R5 still busy", {127'd0, busy_o}, 128'd1);
            while (!done_o && lat < 20) begin
                @(negedge clk);
                lat++;
            end
            check("R5 timing kept", lat, 8);
            check("R5 first operands used", product_o, ref_mul(a1, b1));
            @(negedge clk);
            check("R5 no second run", {127'd0, busy_o}, 128'd0);
        end

        // R6: product held while idle with toggling inputs
        run_op(64'h8000000000000001, 64'hC000000000000003, p);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            a_i = {$urandom(), $urandom()};
            b_i = {$urandom(), $urandom()};
        end
        @(negedge clk);
        check("R6 idle hold", product_o, ref_mul(64'h8000000000000001, 64'hC000000000000003));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule